// File: doc/BRIEF.md
# Receive Line Status with Error-Tagged Queue

This block holds received characters in a queue where each entry carries its own parity, framing and break tags next to the data byte. A read-only status byte reports to a host CPU. The parity, framing and break bits show the tags of the character at the queue head, and only once that character has reached the head. A separate summary bit stays set while any tagged character remains queued. The status byte also reports an overrun when a character arrives at a full queue, and it reports the transmit-side empty state.

The host reads through a small register port. A read of the data address pops the head entry. A read of the status address returns the status byte and clears its sticky bits. A read of any other address has no side effect. In character mode the queue holds a single entry and the summary bit reads 0. Two interrupt requests are produced: one for receiver line status and one for transmit holding empty.

Top module: `rx_line_status`

## Requirements
- R1: After reset the status byte is 0x60 and both interrupt requests are low.
- R2: The status byte bits, from bit 7 down, are: queue error summary, transmitter empty, holding empty, break, framing, parity, overrun, data ready. A read at address 0 returns the head data byte and pops it. A read at address 5 returns the status byte. A read at any other address returns 0 and neither pops nor clears anything.
- R3: Data ready (bit 0) is 1 from the cycle after a character is accepted, and it stays 1 until the queue is empty.
- R4: A character that arrives at a full queue, with no pop in the same cycle, replaces the most recently written entry and sets overrun (bit 1). Overrun stays set until a status read. If a status read and a new overrun fall in the same cycle, overrun remains set.
- R5: The parity tag (rx_par_err_i) appears in bit 2, the framing tag (rx_frm_err_i) in bit 3 and the break tag (rx_brk_i) in bit 4. Each appears as soon as the tagged character is at the head. Once shown, the bit stays set after that character is popped, until a status read clears it.
- R6: Tags belong to their own character. A tagged character behind a clean head does not set bits 2 to 4.
- R7: In queue mode, bit 7 is set from the cycle after a tagged character is accepted. A status read clears it only when no tagged character remains queued. A tagged arrival in the same cycle as the read keeps it set.
- R8: In character mode (fifo_en_i = 0) the queue holds one entry and bit 7 reads 0.
- R9: Holding empty (bit 5) follows tx_fifo_empty_i one cycle late. Transmitter empty (bit 6) follows tx_fifo_empty_i AND tx_shift_empty_i one cycle late.
- R10: thre_irq_o equals thre_ie_i AND bit 5.
- R11: rls_irq_o is high whenever any of bits 1 to 4 is set.
- R12: In queue mode the queue holds 16 entries and returns them in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = queue mode, 0 = character mode |
| rx_valid_i | input | 1 | Character received strobe |
| rx_data_i | input | 8 | Received character |
| rx_par_err_i | input | 1 | Parity error tag for the character |
| rx_frm_err_i | input | 1 | Stop bit sampled low |
| rx_brk_i | input | 1 | Line held low beyond one frame time |
| tx_fifo_empty_i | input | 1 | Transmit queue / holding register is empty |
| tx_shift_empty_i | input | 1 | Transmit shifter is idle |
| thre_ie_i | input | 1 | Holding-empty interrupt enable |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 3 | Host register address |
| rd_data_o | output | 8 | Read data for the addressed register |
| lsr_o | output | 8 | Live status byte |
| rls_irq_o | output | 1 | Receiver line status interrupt request |
| thre_irq_o | output | 1 | Holding-empty interrupt request |

## Verification
A status read can fall in the same cycle as a character arrival. The arrival may be either an overrun into a full queue or a tagged character into an empty one. The bench provokes both by raising rd_i at the status address and rx_valid_i on the same clock edge. It then judges that the read returns the pre-edge status, and that overrun or the summary bit is still set on the next read. Pops of tagged and clean heads are interleaved with status reads to separate the head-tag bits from the summary bit.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_PE   = 2;
  localparam int LSR_FE   = 3;
  localparam int LSR_BI   = 4;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int LSR_SUM  = 7;
endpackage

// File: rtl/rls_fifo.sv
module rls_fifo
  import rls_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             single_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  rx_entry_t        din_i,
  output rx_entry_t        head_o,
  output logic [TAG_W-1:0] old_tag_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             ovw_o,
  output logic             head_chg_o
);
  rx_entry_t         mem [DEPTH];
  logic [AW-1:0]     wr_q, rd_q, last_idx;
  logic [CW-1:0]     cnt_q;
  logic              empty;

  assign empty    = (cnt_q == '0);
  assign full_o   = single_i ? !empty : (cnt_q == CW'(DEPTH));
  assign last_idx = wr_q - AW'(1);

  assign pop_ok_o  = pop_i & !empty;
  assign ovw_o     = push_i & full_o & !pop_ok_o;
  assign push_ok_o = push_i & !ovw_o;

  // overwrite of the only entry replaces the head
  assign head_chg_o = pop_ok_o | (ovw_o & (cnt_q == CW'(1)));

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem[wr_q] <= din_i;
    else if (ovw_o) mem[last_idx] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok_o) wr_q <= wr_q + AW'(1);
      if (pop_ok_o)  rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_ok_o) - CW'(pop_ok_o);
    end
  end

  assign head_o    = mem[rd_q];
  assign old_tag_o = {mem[last_idx].brk, mem[last_idx].frm, mem[last_idx].par};
  assign count_o   = cnt_q;
endmodule

// File: rtl/rls_err_cnt.sv
module rls_err_cnt #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          ovw_i,
  input  logic          new_tag_i,
  input  logic          head_tag_i,
  input  logic          old_tag_i,
  output logic [CW-1:0] err_cnt_o,
  output logic          err_in_o
);
  logic [CW-1:0] cnt_q;
  logic          inc, dec;

  assign err_in_o = (push_i | ovw_i) & new_tag_i;
  assign inc      = err_in_o;
  assign dec      = (pop_i & head_tag_i) | (ovw_i & old_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(inc) - CW'(dec);
  end

  assign err_cnt_o = cnt_q;
endmodule

// File: rtl/rls_status.sv
module rls_status
  import rls_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             head_valid_i,
  input  logic [TAG_W-1:0] head_tag_i,
  input  logic             head_chg_i,
  input  logic             ovw_i,
  input  logic             err_in_i,
  input  logic             err_none_i,
  input  logic             lsr_rd_i,
  input  logic             tx_fifo_empty_i,
  input  logic             tx_shift_empty_i,
  input  logic             thre_ie_i,
  output logic [7:0]       lsr_o,
  output logic             rls_irq_o,
  output logic             thre_irq_o
);
  logic [TAG_W-1:0] tag_q, pend;
  logic oe_q, rep_q, sum_q, thre_q, temt_q;

  // head tags not yet folded into the sticky bits
  assign pend = (head_valid_i && !rep_q) ? head_tag_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      oe_q   <= 1'b0;
      rep_q  <= 1'b0;
      sum_q  <= 1'b0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
    end else begin
      tag_q <= lsr_rd_i ? '0 : (tag_q | pend);

      if (ovw_i)         oe_q <= 1'b1;
      else if (lsr_rd_i) oe_q <= 1'b0;

      if (head_chg_i)        rep_q <= 1'b0;
      else if (head_valid_i) rep_q <= 1'b1;

      if (err_in_i)                      sum_q <= 1'b1;
      else if (lsr_rd_i && err_none_i)   sum_q <= 1'b0;

      thre_q <= tx_fifo_empty_i;
      temt_q <= tx_fifo_empty_i & tx_shift_empty_i;
    end
  end

  logic [TAG_W-1:0] tag_vis;
  assign tag_vis = tag_q | pend;

  always_comb begin
    lsr_o           = '0;
    lsr_o[LSR_DR]   = head_valid_i;
    lsr_o[LSR_OE]   = oe_q;
    lsr_o[LSR_PE]   = tag_vis[0];
    lsr_o[LSR_FE]   = tag_vis[1];
    lsr_o[LSR_BI]   = tag_vis[2];
    lsr_o[LSR_THRE] = thre_q;
    lsr_o[LSR_TEMT] = temt_q;
    lsr_o[LSR_SUM]  = fifo_en_i & sum_q;
  end

  assign rls_irq_o  = oe_q | (|tag_vis);
  assign thre_irq_o = thre_ie_i & thre_q;
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rls_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ADDR_W    = 3,
  parameter int DATA_ADDR = 0,
  parameter int LSR_ADDR  = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  input  logic              rx_brk_i,
  input  logic              tx_fifo_empty_i,
  input  logic              tx_shift_empty_i,
  input  logic              thre_ie_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [7:0]        lsr_o,
  output logic              rls_irq_o,
  output logic              thre_irq_o
);
  rx_entry_t        din, head;
  logic [TAG_W-1:0] old_tag, head_tag;
  logic [CW-1:0]    count, err_cnt;
  logic full, push_ok, pop_ok, ovw, head_chg, err_in;
  logic data_rd, lsr_rd;

  assign data_rd = rd_i && (addr_i == ADDR_W'(DATA_ADDR));
  assign lsr_rd  = rd_i && (addr_i == ADDR_W'(LSR_ADDR));

  assign din      = '{brk: rx_brk_i, frm: rx_frm_err_i, par: rx_par_err_i, data: rx_data_i};
  assign head_tag = {head.brk, head.frm, head.par};

  rls_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .single_i   (!fifo_en_i),
    .push_i     (rx_valid_i),
    .pop_i      (data_rd),
    .din_i      (din),
    .head_o     (head),
    .old_tag_o  (old_tag),
    .count_o    (count),
    .full_o     (full),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .ovw_o      (ovw),
    .head_chg_o (head_chg)
  );

  rls_err_cnt #(.DEPTH(DEPTH)) u_err (
    .clk_i, .rst_ni,
    .push_i     (push_ok),
    .pop_i      (pop_ok),
    .ovw_i      (ovw),
    .new_tag_i  (|{rx_par_err_i, rx_frm_err_i, rx_brk_i}),
    .head_tag_i (|head_tag),
    .old_tag_i  (|old_tag),
    .err_cnt_o  (err_cnt),
    .err_in_o   (err_in)
  );

  rls_status u_stat (
    .clk_i, .rst_ni,
    .fifo_en_i,
    .head_valid_i     (count != '0),
    .head_tag_i       (head_tag),
    .head_chg_i       (head_chg),
    .ovw_i            (ovw),
    .err_in_i         (err_in),
    .err_none_i       (err_cnt == '0),
    .lsr_rd_i         (lsr_rd),
    .tx_fifo_empty_i,
    .tx_shift_empty_i,
    .thre_ie_i,
    .lsr_o,
    .rls_irq_o,
    .thre_irq_o
  );

  always_comb begin
    if (data_rd)     rd_data_o = head.data;
    else if (lsr_rd) rd_data_o = lsr_o;
    else             rd_data_o = '0;
  end
endmodule

// File: rtl/rls_checker.sv
module rls_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          rx_valid_i,
  input logic          lsr_rd,
  input logic          full,
  input logic          pop_ok,
  input logic [7:0]    lsr_o,
  input logic          thre_irq_o,
  input logic [CW-1:0] err_cnt,
  input logic [CW-1:0] count
);
  AST_DR_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> lsr_o[0]); // R3
  AST_OVR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && full && !pop_ok |=> lsr_o[1]); // R4
  AST_OVR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd && !rx_valid_i |=> !lsr_o[1]); // R4
  AST_ERR_LE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt <= count); // R6
  AST_SUM_QUEUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && (err_cnt != '0) |-> lsr_o[7]); // R7
  AST_CHAR_NO_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> !lsr_o[7]); // R8
  AST_THRE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thre_irq_o |-> lsr_o[5]); // R10
endmodule

bind rx_line_status rls_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i), .rx_valid_i(rx_valid_i),
  .lsr_rd(lsr_rd), .full(full), .pop_ok(pop_ok), .lsr_o(lsr_o),
  .thre_irq_o(thre_irq_o), .err_cnt(err_cnt), .count(count)
);

// File: tb/sim_rx_line_status.sv
`timescale 1ns/1ps
module sim_rx_line_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b0, rx_valid = 1'b0, par = 1'b0, frm = 1'b0, brk = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_fe = 1'b1, tx_se = 1'b1, thre_ie = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] rd_data, lsr;
  logic rls_irq, thre_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_line_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_par_err_i(par), .rx_frm_err_i(frm), .rx_brk_i(brk),
    .tx_fifo_empty_i(tx_fe), .tx_shift_empty_i(tx_se), .thre_ie_i(thre_ie),
    .rd_i(rd), .addr_i(addr), .rd_data_o(rd_data), .lsr_o(lsr),
    .rls_irq_o(rls_irq), .thre_irq_o(thre_irq)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one clock: optional push and optional read; v = read data before the edge
  task automatic cyc(input bit v_in, input logic [7:0] d, input bit p, input bit f,
                     input bit b, input bit r, input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rx_valid = v_in; rx_data = d; par = p; frm = f; brk = b; rd = r; addr = a;
    #1 v = rd_data;
    @(posedge clk);
    #1 rx_valid = 0; par = 0; frm = 0; brk = 0; rd = 0;
  endtask

  task automatic push(input logic [7:0] d, input bit p, input bit f, input bit b);
    logic [7:0] v;
    cyc(1, d, p, f, b, 0, 3'd0, v);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    cyc(0, 8'h00, 0, 0, 0, 1, a, v);
  endtask

  task automatic look(string tag, logic [7:0] exp);
    @(negedge clk);
    chk(tag, lsr, exp);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset lsr", lsr, 8'h60);
    chk("R1 reset irqs", {6'd0, rls_irq, thre_irq}, 8'h00);

    // transmit side
    thre_ie = 1;
    @(negedge clk); chk("R10 thre irq on", {7'd0, thre_irq}, 8'h01);
    tx_fe = 0;
    @(negedge clk); chk("R9 tx busy", lsr, 8'h00);
    chk("R10 thre irq off", {7'd0, thre_irq}, 8'h00);
    tx_fe = 1; tx_se = 0;
    @(negedge clk); chk("R9 shifter busy", lsr, 8'h20);
    tx_se = 1; thre_ie = 0;
    look("R9 idle", 8'h60);

    // fill 16, then overrun
    fifo_en = 1;
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 3), 0, 0, 0);
    look("R3 dr set", 8'h61);
    push(8'hAA, 0, 0, 0);
    look("R4 overrun", 8'h63);
    chk("R11 irq on overrun", {7'd0, rls_irq}, 8'h01);
    rd_reg(3'd5, v); chk("R2 lsr read", v, 8'h63);
    look("R4 cleared", 8'h61);
    for (int i = 0; i < 16; i++) begin
      rd_reg(3'd0, v);
      chk("R12 order", v, (i == 15) ? 8'hAA : 8'(i * 7 + 3));
    end
    look("R3 dr drop", 8'h60);

    // tagged characters
    push(8'h11, 0, 0, 0);
    push(8'h22, 1, 0, 0);
    push(8'h33, 0, 1, 0);
    push(8'h44, 0, 0, 1);
    look("R6 clean head", 8'hE1);
    chk("R11 no irq", {7'd0, rls_irq}, 8'h00);
    rd_reg(3'd4, v); chk("R2 other addr data", v, 8'h00);
    look("R2 other addr no effect", 8'hE1);
    rd_reg(3'd0, v); chk("R2 pop data", v, 8'h11);
    look("R5 parity head", 8'hE5);
    chk("R11 irq on parity", {7'd0, rls_irq}, 8'h01);
    rd_reg(3'd5, v); chk("R5 read parity", v, 8'hE5);
    look("R7 sum kept", 8'hE1);
    rd_reg(3'd0, v); chk("R12 pop b", v, 8'h22);
    look("R5 framing head", 8'hE9);
    rd_reg(3'd0, v); chk("R12 pop c", v, 8'h33);
    look("R5 sticky framing plus break", 8'hF9);
    rd_reg(3'd5, v); chk("R5 read both", v, 8'hF9);
    look("R5 cleared", 8'hE1);
    rd_reg(3'd0, v); chk("R12 pop d", v, 8'h44);
    look("R7 sum after drain", 8'hE0);
    rd_reg(3'd5, v);
    look("R7 sum cleared", 8'h60);

    // same-cycle: tagged arrival with status read
    cyc(1, 8'h55, 1, 0, 0, 1, 3'd5, v);
    chk("R7 read before arrival", v, 8'h60);
    look("R7 arrival wins", 8'hE5);
    rd_reg(3'd0, v); chk("R12 pop tagged", v, 8'h55);
    look("R5 sticky after pop", 8'hE4);
    rd_reg(3'd5, v);
    look("R7 cleared empty", 8'h60);

    // same-cycle: overrun with status read
    for (int i = 0; i < 16; i++) push(8'(i), 0, 0, 0);
    cyc(1, 8'h77, 0, 0, 0, 1, 3'd5, v);
    chk("R4 read before overrun", v, 8'h61);
    look("R4 overrun wins", 8'h63);
    rd_reg(3'd5, v);
    for (int i = 0; i < 16; i++) begin
      rd_reg(3'd0, v);
      chk("R4 newest replaced", v, (i == 15) ? 8'h77 : 8'(i));
    end
    look("R3 empty again", 8'h60);

    // character mode
    fifo_en = 0;
    push(8'h5A, 0, 1, 0);
    look("R8 char framing", 8'h69);
    push(8'hA5, 0, 0, 0);
    look("R8 char overrun", 8'h6B);
    rd_reg(3'd0, v); chk("R8 char data", v, 8'hA5);
    rd_reg(3'd5, v); chk("R8 char lsr", v, 8'h6A);
    look("R8 char clear", 8'h60);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule